// File: doc/BRIEF.md
# Power State Handshake Controller

This block sequences two analog power domains, a PHY and a PLL, from the digital side. Software writes a 2-bit target state for each domain into one control word. The block then moves that domain toward the target. It shows the state the domain has actually reached in a separate 2-bit status field of the same word. Software polls the status field and treats a mismatch that lasts too long as a failure.

The end of a transition is decided per domain. In timer mode, a programmable settle count must run out. In acknowledge mode, the domain's acknowledge input must arrive. A new target written while a transition is pending restarts the settle sequence toward that target. A target equal to the reached state starts nothing. The commanded state of each domain is driven out continuously as the power request to the analog side.

Top module: `pwrhs_top`

## Requirements
- R1: Address 0 is the control word. PHY command is bits 7:6 and PLL command is bits 3:2. Every write to address 0 loads both command fields, and each can be read back. `phyPwrReq` and `pllPwrReq` show the current commands from the cycle after the write.
- R2: In the control word, PHY status is bits 5:4 and PLL status is bits 1:0. A status field changes only when a pending transition completes, and it then takes the value of that domain's command.
- R3: In timer mode, a write at clock edge k whose command differs from the status starts a transition. The status equals the command after edge k+D+1 and not before. D is the domain's delay field, so D=0 completes at edge k+1.
- R4: In acknowledge mode, a pending transition completes at the first clock edge where that domain's acknowledge input is high. An acknowledge while the domain is idle has no effect.
- R5: A written command equal to the current status starts no transition. It also abandons any pending transition, and the status keeps its value.
- R6: A different command written during a pending transition restarts the full settle sequence toward the new command. The old schedule is discarded.
- R7: Write data in the status bit positions is ignored, and status fields change only through R2.
- R8: After reset, the control word and both configuration words read 0, meaning both domains are off, in timer mode, with delay 0.
- R9: The two domains sequence independently; a transition or acknowledge of one never moves the other's status.
- R10: Address 1 configures the PHY and address 2 configures the PLL. Bit 31 selects acknowledge mode (1) or timer mode (0), and bits CNT_W-1:0 hold the delay. Both fields read back, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| phyAck | input | 1 | PHY settle acknowledge |
| pllAck | input | 1 | PLL settle acknowledge |
| phyPwrReq | output | 2 | Commanded PHY power state |
| pllPwrReq | output | 2 | Commanded PLL power state |

## Verification
A wrong settle counter shows as a status field that turns one or more cycles early or late against the k+D+1 edge. A dropped busy flag shows as a status that never follows its command. A lost restart shows as a status that lands on the superseded target three edges into the new window. Because the control word is combinational on the read port, any status, command or configuration error appears within one cycle of the faulty edge. The bench compares the full read word after every clock against a behavioural model, so such an error is reported on the first cycle it exists.

// File: rtl/pwrhs_pkg.sv
package pwrhs_pkg;
  localparam int NDOM      = 2;   // domain 0 = PHY, domain 1 = PLL
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 32;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CFG0 = 1;   // configuration of domain d at ADDR_CFG0 + d
  localparam int MODE_BIT  = 31;

  // command field LSB and status field LSB of domain d inside the control word
  function automatic int cmdLsb(input int d);
    return 6 - 4 * d;
  endfunction

  function automatic int statLsb(input int d);
    return 4 - 4 * d;
  endfunction

  typedef struct packed {
    logic cmdLoad;
    logic settleStart;
    logic settleCancel;
    logic settleDone;
    logic settleTick;
    logic cfgLoad;
  } domStrobe_t;
endpackage

// File: rtl/pwrhs_ctrl.sv
module pwrhs_ctrl
  import pwrhs_pkg::*;
(
  input  logic                            regWr,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [NDOM-1:0][1:0]            newCmdVec,
  input  logic [NDOM-1:0][1:0]            statVec,
  input  logic [NDOM-1:0]                 busyVec,
  input  logic [NDOM-1:0]                 cntZeroVec,
  input  logic [NDOM-1:0]                 ackModeVec,
  input  logic [NDOM-1:0]                 ackVec,
  output domStrobe_t [NDOM-1:0]           strobeVec
);
  logic wrCtrl;
  assign wrCtrl = regWr && (regAddr == ADDR_W'(ADDR_CTRL));

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic sameTarget;
    logic settleReady;
    assign sameTarget  = (newCmdVec[d] == statVec[d]);
    assign settleReady = ackModeVec[d] ? ackVec[d] : cntZeroVec[d];

    always_comb begin
      strobeVec[d]              = '0;
      strobeVec[d].cmdLoad      = wrCtrl;
      strobeVec[d].settleStart  = wrCtrl && !sameTarget;
      strobeVec[d].settleCancel = wrCtrl && sameTarget;
      strobeVec[d].settleDone   = !wrCtrl && busyVec[d] && settleReady;
      strobeVec[d].settleTick   = !wrCtrl && busyVec[d] && !ackModeVec[d] && !cntZeroVec[d];
      strobeVec[d].cfgLoad      = regWr && (regAddr == ADDR_W'(ADDR_CFG0 + d));
    end
  end
endmodule

// File: rtl/pwrhs_dp.sv
module pwrhs_dp
  import pwrhs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  domStrobe_t [NDOM-1:0]           strobeVec,
  input  logic [NDOM-1:0][1:0]            newCmdVec,
  input  logic [CNT_W-1:0]                cfgDelay,
  input  logic                            cfgMode,
  output logic [NDOM-1:0][1:0]            cmdVec,
  output logic [NDOM-1:0][1:0]            statVec,
  output logic [NDOM-1:0]                 busyVec,
  output logic [NDOM-1:0]                 cntZeroVec,
  output logic [NDOM-1:0]                 ackModeVec,
  output logic [NDOM-1:0][CNT_W-1:0]      dlyVec
);
  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic [CNT_W-1:0] cntQ;

    assign cntZeroVec[d] = (cntQ == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyVec[d]     <= '0;
        ackModeVec[d] <= 1'b0;
      end else if (strobeVec[d].cfgLoad) begin
        dlyVec[d]     <= cfgDelay;
        ackModeVec[d] <= cfgMode;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdVec[d] <= 2'b00;
      end else if (strobeVec[d].cmdLoad) begin
        cmdVec[d] <= newCmdVec[d];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statVec[d] <= 2'b00;
        busyVec[d] <= 1'b0;
        cntQ       <= '0;
      end else if (strobeVec[d].settleStart) begin
        busyVec[d] <= 1'b1;
        cntQ       <= dlyVec[d];
      end else if (strobeVec[d].settleCancel) begin
        busyVec[d] <= 1'b0;
      end else if (strobeVec[d].settleDone) begin
        statVec[d] <= cmdVec[d];
        busyVec[d] <= 1'b0;
      end else if (strobeVec[d].settleTick) begin
        cntQ <= cntQ - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pwrhs_top.sv
module pwrhs_top
  import pwrhs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              phyAck,
  input  logic              pllAck,
  output logic [1:0]        phyPwrReq,
  output logic [1:0]        pllPwrReq
);
  logic [NDOM-1:0][1:0]       newCmdVec;
  logic [NDOM-1:0][1:0]       cmdVec;
  logic [NDOM-1:0][1:0]       statVec;
  logic [NDOM-1:0]            busyVec;
  logic [NDOM-1:0]            cntZeroVec;
  logic [NDOM-1:0]            ackModeVec;
  logic [NDOM-1:0]            ackVec;
  logic [NDOM-1:0][CNT_W-1:0] dlyVec;
  domStrobe_t [NDOM-1:0]      strobeVec;
  logic                       unusedWdata;

  assign unusedWdata = ^regWdata;
  assign ackVec      = {pllAck, phyAck};

  for (genvar d = 0; d < NDOM; d++) begin : g_field
    assign newCmdVec[d] = regWdata[cmdLsb(d) +: 2];
  end

  pwrhs_ctrl ctrl_i (
    .regWr      (regWr),
    .regAddr    (regAddr),
    .newCmdVec  (newCmdVec),
    .statVec    (statVec),
    .busyVec    (busyVec),
    .cntZeroVec (cntZeroVec),
    .ackModeVec (ackModeVec),
    .ackVec     (ackVec),
    .strobeVec  (strobeVec)
  );

  pwrhs_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobeVec  (strobeVec),
    .newCmdVec  (newCmdVec),
    .cfgDelay   (regWdata[CNT_W-1:0]),
    .cfgMode    (regWdata[MODE_BIT]),
    .cmdVec     (cmdVec),
    .statVec    (statVec),
    .busyVec    (busyVec),
    .cntZeroVec (cntZeroVec),
    .ackModeVec (ackModeVec),
    .dlyVec     (dlyVec)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      for (int i = 0; i < NDOM; i++) begin
        regRdata[cmdLsb(i) +: 2]  = cmdVec[i];
        regRdata[statLsb(i) +: 2] = statVec[i];
      end
    end
    for (int i = 0; i < NDOM; i++) begin
      if (regAddr == ADDR_W'(ADDR_CFG0 + i)) begin
        regRdata[MODE_BIT]    = ackModeVec[i];
        regRdata[CNT_W-1:0]   = dlyVec[i];
      end
    end
  end

  assign phyPwrReq = cmdVec[0];
  assign pllPwrReq = cmdVec[1];
endmodule

// File: rtl/pwrhs_chk.sv
module pwrhs_chk
  import pwrhs_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWr,
  input logic [1:0]           regAddr,
  input logic [31:0]          regWdata,
  input logic [NDOM-1:0][1:0] cmdVec,
  input logic [NDOM-1:0][1:0] statVec,
  input logic [NDOM-1:0]      busyVec,
  input logic [NDOM-1:0]      ackModeVec,
  input logic [NDOM-1:0]      ackVec
);
  logic wrCtrl;
  assign wrCtrl = regWr && (regAddr == 2'd0);

  AST_RESET_OFF: assert property (@(posedge clk)
    !rstN |=> (cmdVec == '0) && (statVec == '0)); // R8

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    localparam int CL = 6 - 4 * d;

    AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      wrCtrl |=> cmdVec[d] == $past(regWdata[CL +: 2])); // R1

    AST_STATUS_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(statVec[d]) |-> statVec[d] == $past(cmdVec[d])); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!busyVec[d] && !wrCtrl) |=> $stable(statVec[d])); // R9

    AST_ACK_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
      (busyVec[d] && ackModeVec[d] && ackVec[d] && !wrCtrl)
        |=> !busyVec[d] && statVec[d] == $past(cmdVec[d])); // R4

    AST_ACK_WAIT: assert property (@(posedge clk) disable iff (!rstN)
      (busyVec[d] && ackModeVec[d] && !ackVec[d] && !wrCtrl) |=> busyVec[d]); // R4

    AST_SAME_NO_START: assert property (@(posedge clk) disable iff (!rstN)
      (wrCtrl && regWdata[CL +: 2] == statVec[d])
        |=> !busyVec[d] && $stable(statVec[d])); // R5

    AST_NEW_RESTART: assert property (@(posedge clk) disable iff (!rstN)
      (wrCtrl && regWdata[CL +: 2] != statVec[d])
        |=> busyVec[d] && $stable(statVec[d])); // R6
  end
endmodule

bind pwrhs_top pwrhs_chk chk_i (.*);

// File: tb/pwrhs_top_tb_top.sv
module pwrhs_top_tb_top;
  localparam int CNT_W = 12;
  localparam int DMASK = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        phyAck = 1'b0;
  logic        pllAck = 1'b0;
  logic [1:0]  phyPwrReq;
  logic [1:0]  pllPwrReq;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwrhs_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .phyAck(phyAck),
    .pllAck(pllAck), .phyPwrReq(phyPwrReq), .pllPwrReq(pllPwrReq)
  );

  // behavioural reference: per domain target, reached state, edges left
  int mCmd[2], mStat[2], mBusy[2], mLeft[2], mDly[2], mAckMode[2];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < 2; d++) begin
        mCmd[d] = 0; mStat[d] = 0; mBusy[d] = 0;
        mLeft[d] = 0; mDly[d] = 0; mAckMode[d] = 0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        int ack;
        ack = (d == 0) ? int'(phyAck) : int'(pllAck);
        if (regWr && regAddr == 2'd0) begin
          mCmd[d] = int'((regWdata >> (6 - 4 * d)) & 32'h3);
          if (mCmd[d] != mStat[d]) begin
            mBusy[d] = 1;
            mLeft[d] = mDly[d] + 1;
          end else begin
            mBusy[d] = 0;
          end
        end else if (mBusy[d] != 0) begin
          if (mAckMode[d] != 0) begin
            if (ack != 0) begin mStat[d] = mCmd[d]; mBusy[d] = 0; end
          end else begin
            mLeft[d] = mLeft[d] - 1;
            if (mLeft[d] == 0) begin mStat[d] = mCmd[d]; mBusy[d] = 0; end
          end
        end
        if (regWr && int'(regAddr) == 1 + d) begin
          mDly[d]     = int'(regWdata) & DMASK;
          mAckMode[d] = int'(regWdata[31]);
        end
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 2'd0) begin
      v = 32'((mCmd[0] << 6) | (mStat[0] << 4) | (mCmd[1] << 2) | mStat[1]);
    end else if (a == 2'd1 || a == 2'd2) begin
      v = 32'(mDly[int'(a) - 1]);
      v[31] = mAckMode[int'(a) - 1][0];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      chk("R2 model read word", regRdata, modelRead(regAddr));
      chk("R1 model requests", {28'd0, phyPwrReq, pllPwrReq},
          32'((mCmd[0] << 2) | mCmd[1]));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);
    peek(2'd0, v); chk("R8 control after reset", v, 32'h0);
    peek(2'd1, v); chk("R8 phy config after reset", v, 32'h0);
    peek(2'd2, v); chk("R8 pll config after reset", v, 32'h0);

    // configuration: PHY timer delay 5, PLL acknowledge mode
    wr(2'd1, 32'h0000_0005);
    peek(2'd1, v); chk("R10 phy config readback", v, 32'h0000_0005);
    wr(2'd2, 32'h8000_0000);
    peek(2'd2, v); chk("R10 pll config readback", v, 32'h8000_0000);
    peek(2'd3, v); chk("R10 unused address", v, 32'h0);

    // timer transition PHY 0 -> 3
    wr(2'd0, 32'h0000_00C0);
    peek(2'd0, v); chk("R1 command loaded", v, 32'h0000_00C0);
    chk("R1 phy request", {30'd0, phyPwrReq}, 32'd3);
    waitEdges(5);
    peek(2'd0, v); chk("R3 not before k+D+1", v, 32'h0000_00C0);
    waitEdges(1);
    peek(2'd0, v); chk("R3 reached at k+D+1", v, 32'h0000_00F0);

    // acknowledge transition PLL 0 -> 2
    wr(2'd0, 32'h0000_00C8);
    waitEdges(4);
    peek(2'd0, v); chk("R4 waits for acknowledge", v, 32'h0000_00F8);
    pllAck = 1'b1; @(negedge clk); pllAck = 1'b0;
    peek(2'd0, v); chk("R4 acknowledge completes", v, 32'h0000_00FA);
    pllAck = 1'b1; phyAck = 1'b1; @(negedge clk); pllAck = 1'b0; phyAck = 1'b0;
    peek(2'd0, v); chk("R4 idle acknowledge ignored", v, 32'h0000_00FA);

    // status bits in write data are ignored
    wr(2'd0, 32'h0000_00C9);
    peek(2'd0, v); chk("R7 status write ignored", v, 32'h0000_00FA);
    waitEdges(3);
    peek(2'd0, v); chk("R5 equal command starts nothing", v, 32'h0000_00FA);

    // restart: PHY to 1, then redirected to 2 after two more edges
    wr(2'd0, 32'h0000_0048);
    peek(2'd0, v); chk("R6 first target pending", v, 32'h0000_007A);
    waitEdges(2);
    wr(2'd0, 32'h0000_0088);
    peek(2'd0, v); chk("R6 redirected", v, 32'h0000_00BA);
    waitEdges(5);
    peek(2'd0, v); chk("R6 old schedule discarded", v, 32'h0000_00BA);
    waitEdges(1);
    peek(2'd0, v); chk("R6 new target reached", v, 32'h0000_00AA);

    // abandon: PHY toward 0, then command equal to status
    wr(2'd0, 32'h0000_0008);
    peek(2'd0, v); chk("R2 status held while pending", v, 32'h0000_002A);
    waitEdges(2);
    wr(2'd0, 32'h0000_0088);
    waitEdges(10);
    peek(2'd0, v); chk("R5 pending transition abandoned", v, 32'h0000_00AA);

    // independence, PHY delay 0
    wr(2'd1, 32'h0000_0000);
    peek(2'd1, v); chk("R10 delay rewritten", v, 32'h0);
    wr(2'd0, 32'h0000_0044);
    peek(2'd0, v); chk("R9 both pending", v, 32'h0000_0066);
    waitEdges(1);
    peek(2'd0, v); chk("R3 zero delay completes at k+1", v, 32'h0000_0056);
    waitEdges(3);
    peek(2'd0, v); chk("R9 pll unaffected by phy", v, 32'h0000_0056);
    pllAck = 1'b1; @(negedge clk); pllAck = 1'b0;
    peek(2'd0, v); chk("R9 pll completes alone", v, 32'h0000_0055);
    chk("R1 final requests", {28'd0, phyPwrReq, pllPwrReq}, 32'h5);

    waitEdges(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule